// File: doc/BRIEF.md
# Soft Mute Ramp Controller

This block produces a gain coefficient that glides between silence and full level instead of jumping. A mute is requested either by an active-low external pin or by a control bit; the pin is brought into the clock domain first. When the request changes, the block walks a level index one step at a time through a computed S-shaped curve. The curve is flat near both ends and steep in the middle, so the audible change is gentle where the ear is most sensitive.

The pace of each ramp is chosen by a two-bit time select, which is captured when a ramp begins. A ramp, once started, always reaches its end point; only then is the request looked at again. A busy flag rises when a mute ramp begins and stays up through the muted period and the following unmute ramp, falling only when full level is reached again. The gain word is meant to be multiplied into the audio path elsewhere.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is the OR of the control bit `mute_reg` (1 = mute) and the inverted pin `mute_pin_n` (0 = mute). The pin passes through a two-stage synchronizer, so it acts two clock cycles later than the control bit.
- R2: `time_sel` sets the clock cycles spent on each level step: 2'b00 selects STEP_CYC_FAST, 2'b01 selects STEP_CYC_MID, and 2'b10 or 2'b11 selects STEP_CYC_SLOW. A ramp starts on the clock edge after the request is seen. A complete ramp takes STEPS times that count. The defaults give about 0.48 ms, 0.96 ms and 123 ms at 50 MHz.
- R3: At level k (0..STEPS), `gain` equals floor(2^(GAIN_W-1) * (3*k*k*STEPS - 2*k*k*k) / STEPS^3). Each change of `gain` moves exactly one level. The ramp is monotonic in its direction.
- R4: `busy` rises on the edge where a mute ramp starts. It stays 1 through the muted state and the unmute ramp, and it falls on the edge where `gain` reaches full level.
- R5: A ramp in progress runs to its end point whatever the request does. `time_sel` is sampled only when a ramp starts.
- R6: In the muted state `gain` is 0. In the unmuted state `gain` is 2^(GAIN_W-1).
- R7: After a ramp ends, the end state lasts exactly one cycle if the request then calls for the opposite direction. The opposite ramp starts on the following edge.
- R8: Reset puts the block in the muted state with `gain` 0 and `busy` 0. The unmute ramp that follows reset, with no earlier mute ramp, leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mute_pin_n | input | 1 | External mute request, active low, asynchronous |
| mute_reg | input | 1 | Mute request from a control register, active high |
| time_sel | input | 2 | Ramp time select |
| gain | output | GAIN_W | Gain coefficient, unity = 2^(GAIN_W-1) |
| busy | output | 1 | Mute action in progress |

## Verification
The ramp is driven from the control bit alone, from the pin alone, and from both together. The two request paths are told apart by their two-cycle difference in start time. Releasing one source while the other still holds mute shows the OR. Every time-select code is tried, and one slow ramp has its select changed midway, which separates a captured select from a live one. Another mute ramp has its request withdrawn early: the complete descending curve, a zero plateau of exactly one step plus one cycle, and the ascending curve with `busy` held throughout show that nothing is aborted and that the busy span is right.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [1:0] {
        ST_MUTED = 2'd0,
        ST_RISE  = 2'd1,
        ST_OPEN  = 2'd2,
        ST_FALL  = 2'd3
    } smr_state_e;

    // Smoothstep point: unity * (3k^2 S - 2k^3) / S^3
    function automatic longint curve_point(input int k, input int steps, input int w);
        longint unity;
        longint num;
        longint den;
        unity = longint'(1) << (w - 1);
        num   = unity * (3 * longint'(k) * k * steps - 2 * longint'(k) * k * k);
        den   = longint'(steps) * steps * steps;
        return num / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/smr_sync.sv
module smr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_n_sync
);
    typedef struct packed {
        logic meta;
        logic stable;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.meta   = pin_n;
        r_d.stable = r_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{meta: 1'b1, stable: 1'b1};
        else        r_q <= r_d;
    end

    assign pin_n_sync = r_q.stable;
endmodule

// File: rtl/smr_pacer.sv
module smr_pacer #(
    parameter int STEP_CYC_FAST = 750,
    parameter int STEP_CYC_MID  = 1500,
    parameter int STEP_CYC_SLOW = 192188
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       active,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAX_CYC = smr_pkg::max3(STEP_CYC_FAST, STEP_CYC_MID, STEP_CYC_SLOW);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } pace_t;

    pace_t p_d, p_q;

    function automatic logic [CNT_W-1:0] limit_for(input logic [1:0] s);
        case (s)
            2'b00:   return CNT_W'(STEP_CYC_FAST - 1);
            2'b01:   return CNT_W'(STEP_CYC_MID - 1);
            default: return CNT_W'(STEP_CYC_SLOW - 1);
        endcase
    endfunction

    always_comb begin
        p_d = p_q;
        if (start) begin
            p_d.cnt = '0;
            p_d.lim = limit_for(sel);
        end else if (active) begin
            if (p_q.cnt == p_q.lim) p_d.cnt = '0;
            else                    p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign tick = active && (p_q.cnt == p_q.lim);
endmodule

// File: rtl/smr_curve.sv
module smr_curve #(
    parameter int GAIN_W = 16,
    parameter int STEPS  = 32,
    parameter int LVL_W  = $clog2(STEPS + 1)
) (
    input  logic [LVL_W-1:0]  lvl,
    output logic [GAIN_W-1:0] gain
);
    logic [GAIN_W-1:0] tbl [STEPS+1];

    for (genvar k = 0; k <= STEPS; k++) begin : g_pt
        localparam logic [GAIN_W-1:0] PT = GAIN_W'(smr_pkg::curve_point(k, STEPS, GAIN_W));
        assign tbl[k] = PT;
    end

    assign gain = tbl[lvl];
endmodule

// File: rtl/smr_fsm.sv
module smr_fsm
    import smr_pkg::*;
#(
    parameter int STEPS = 32,
    parameter int LVL_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             tick,
    output logic             start,
    output logic [LVL_W-1:0] lvl,
    output logic             busy,
    output smr_state_e       state
);
    typedef struct packed {
        smr_state_e       st;
        logic [LVL_W-1:0] lvl;
        logic             busy;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d   = f_q;
        start = 1'b0;
        case (f_q.st)
            ST_MUTED: begin
                if (!req) begin
                    f_d.st = ST_RISE;
                    start  = 1'b1;
                end
            end
            ST_OPEN: begin
                if (req) begin
                    f_d.st   = ST_FALL;
                    f_d.busy = 1'b1;
                    start    = 1'b1;
                end
            end
            ST_RISE: begin
                if (tick) begin
                    f_d.lvl = f_q.lvl + 1'b1;
                    if (f_q.lvl == LVL_W'(STEPS - 1)) begin
                        f_d.st   = ST_OPEN;
                        f_d.busy = 1'b0;
                    end
                end
            end
            default: begin
                if (tick) begin
                    f_d.lvl = f_q.lvl - 1'b1;
                    if (f_q.lvl == LVL_W'(1)) f_d.st = ST_MUTED;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_MUTED, lvl: '0, busy: 1'b0};
        else        f_q <= f_d;
    end

    assign lvl   = f_q.lvl;
    assign busy  = f_q.busy;
    assign state = f_q.st;
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
    parameter int GAIN_W        = 16,
    parameter int STEPS         = 32,
    parameter int STEP_CYC_FAST = 750,
    parameter int STEP_CYC_MID  = 1500,
    parameter int STEP_CYC_SLOW = 192188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_pin_n,
    input  logic              mute_reg,
    input  logic [1:0]        time_sel,
    output logic [GAIN_W-1:0] gain,
    output logic              busy
);
    localparam int LVL_W = $clog2(STEPS + 1);

    logic                 pin_n_sync;
    logic                 req;
    logic                 start;
    logic                 tick;
    logic                 active;
    logic [LVL_W-1:0]     lvl;
    smr_pkg::smr_state_e  state_w;

    smr_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_n      (mute_pin_n),
        .pin_n_sync (pin_n_sync)
    );

    assign req    = ~pin_n_sync | mute_reg;
    assign active = (state_w == smr_pkg::ST_RISE) || (state_w == smr_pkg::ST_FALL);

    smr_pacer #(
        .STEP_CYC_FAST (STEP_CYC_FAST),
        .STEP_CYC_MID  (STEP_CYC_MID),
        .STEP_CYC_SLOW (STEP_CYC_SLOW)
    ) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .active (active),
        .sel    (time_sel),
        .tick   (tick)
    );

    smr_fsm #(
        .STEPS (STEPS),
        .LVL_W (LVL_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .tick  (tick),
        .start (start),
        .lvl   (lvl),
        .busy  (busy),
        .state (state_w)
    );

    smr_curve #(
        .GAIN_W (GAIN_W),
        .STEPS  (STEPS),
        .LVL_W  (LVL_W)
    ) u_curve (
        .lvl  (lvl),
        .gain (gain)
    );
endmodule

// File: rtl/smr_checker.sv
module smr_checker
    import smr_pkg::*;
#(
    parameter int GAIN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAIN_W-1:0] gain,
    input logic              busy,
    input smr_state_e        state
);
    localparam logic [GAIN_W-1:0] FULL = GAIN_W'(longint'(1) << (GAIN_W - 1));

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r3_fall_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == ST_FALL) |=> (gain <= $past(gain)));

    a_r3_rise_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state == ST_RISE) |=> (gain >= $past(gain)));

    a_r6_muted_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTED) |-> (gain == '0));

    a_r6_open_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> (gain == FULL));

    a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(busy)) |-> (state == ST_FALL && gain == FULL));

    a_r4_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(busy)) |-> (state == ST_OPEN && gain == FULL));

    a_r4_busy_in_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FALL) |-> busy);

    a_r5_fall_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FALL) |=> (state == ST_FALL || state == ST_MUTED));

    a_r5_rise_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE) |=> (state == ST_RISE || state == ST_OPEN));
endmodule

bind soft_mute_ramp smr_checker #(.GAIN_W(GAIN_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .gain  (gain),
    .busy  (busy),
    .state (state_w)
);

// File: tb/soft_mute_ramp_test.sv
module soft_mute_ramp_test;
    localparam int GW = 16;
    localparam int S  = 32;
    localparam int C0 = 2;
    localparam int C1 = 3;
    localparam int C2 = 5;
    localparam logic [GW-1:0] FULL = 16'h8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_n = 1'b1;
    logic          mreg = 1'b1;
    logic [1:0]    sel = 2'b00;
    wire  [GW-1:0] gain;
    wire           busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [GW-1:0] expq [$];
    logic [GW-1:0] last_g = '0;
    bit            mon_en = 1'b0;

    always #10 clk = ~clk;

    soft_mute_ramp #(
        .GAIN_W(GW), .STEPS(S),
        .STEP_CYC_FAST(C0), .STEP_CYC_MID(C1), .STEP_CYC_SLOW(C2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mute_pin_n(pin_n), .mute_reg(mreg),
        .time_sel(sel), .gain(gain), .busy(busy)
    );

    function automatic logic [GW-1:0] pt(input int k);
        longint unity;
        unity = longint'(1) << (GW - 1);
        return GW'((unity * (3 * longint'(k) * k * S - 2 * longint'(k) * k * k))
                   / (longint'(S) * S * S));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue the curve points of one ramp
    task automatic push_ramp(input bit up);
        for (int k = 1; k <= S; k++) expq.push_back(up ? pt(k) : pt(S - k));
    endtask

    // Monitor: every change of gain must be the next queued curve point (R3)
    always @(negedge clk) begin
        if (mon_en && gain != last_g) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3 unexpected gain change", gain, last_g);
            end else begin
                logic [GW-1:0] e;
                e = expq.pop_front();
                check(gain == e, "R3 curve point", gain, e);
            end
            last_g = gain;
        end
    end

    task automatic run_to(input logic [GW-1:0] tgt, input int expn, input int n0, input string tag);
        int n;
        n = n0;
        do begin
            @(negedge clk);
            n++;
        end while (gain != tgt && n < 5000);
        check(n == expn, tag, n, expn);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    initial begin
        // R8: reset state
        repeat (4) @(negedge clk);
        check(gain == '0, "R8 reset gain", gain, 0);
        check(busy == 1'b0, "R8 reset busy", busy, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (10) @(negedge clk);
        check(gain == '0, "R1 control bit holds mute", gain, 0);

        // R8 / R2: first unmute, fast select, busy stays low
        push_ramp(1'b1);
        sel = 2'b00; mreg = 1'b0;
        run_to(FULL, 1 + S * C0, 0, "R2 fast ramp length");
        check(busy == 1'b0, "R8 busy after first unmute", busy, 0);
        check(gain == FULL, "R6 open gain full", gain, FULL);

        // R1: pin path, mid select, two extra sync cycles
        push_ramp(1'b0);
        @(negedge clk); sel = 2'b01; pin_n = 1'b0;
        run_to('0, 3 + S * C1, 0, "R1 pin mute latency and R2 mid length");
        check(busy == 1'b1, "R4 busy held while muted", busy, 1);
        repeat (6) @(negedge clk);
        check(gain == '0, "R6 muted gain zero", gain, 0);
        push_ramp(1'b1);
        pin_n = 1'b1;
        run_to(FULL, 3 + S * C1, 0, "R1 pin unmute length");
        check(busy == 1'b0, "R4 busy falls at full level", busy, 0);

        // R2 slow + R5: select changed mid ramp is not used
        push_ramp(1'b0);
        @(negedge clk); sel = 2'b10; mreg = 1'b1;
        repeat (20) @(negedge clk);
        sel = 2'b00;
        run_to('0, 1 + S * C2, 20, "R5 select captured at ramp start");
        push_ramp(1'b1);
        @(negedge clk); sel = 2'b11; mreg = 1'b0;
        run_to(FULL, 1 + S * C2, 0, "R2 code 11 slow length");

        // R5 / R7: withdraw request during mute ramp
        begin
            int z;
            push_ramp(1'b0);
            push_ramp(1'b1);
            @(negedge clk); sel = 2'b00; mreg = 1'b1;
            repeat (10) @(negedge clk);
            mreg = 1'b0;
            run_to('0, 1 + S * C0, 10, "R5 mute ramp not aborted");
            check(busy == 1'b1, "R4 busy at bottom of reversal", busy, 1);
            z = 0;
            do begin
                @(negedge clk);
                z++;
            end while (gain == '0 && z < 100);
            check(z == C0 + 1, "R7 one cycle at end state then reverse", z, C0 + 1);
            check(busy == 1'b1, "R4 busy during unmute ramp", busy, 1);
            run_to(FULL, (S - 1) * C0, 0, "R7 reverse ramp length");
            check(busy == 1'b0, "R4 busy clear after reversal", busy, 0);
        end

        // R1: both sources, release one only
        push_ramp(1'b0);
        @(negedge clk); pin_n = 1'b0; mreg = 1'b1;
        run_to('0, 1 + S * C0, 0, "R1 both sources mute");
        mreg = 1'b0;
        repeat (50) @(negedge clk);
        check(gain == '0, "R1 pin alone keeps mute", gain, 0);
        push_ramp(1'b1);
        pin_n = 1'b1;
        run_to(FULL, 3 + S * C0, 0, "R1 release of last source");

        repeat (5) @(negedge clk);
        check(expq.size() == 0, "R3 all curve points seen", expq.size(), 0);
        summary();
    end
endmodule